// File: doc/BRIEF.md
# Wavefront Instruction Fetch Arbiter

This block sits in front of the instruction-fetch path of a compute unit that runs several wavefront slots. On every clock it looks at each slot's status (running, how many instructions its buffer holds, whether one of them is a branch, and whether a fetch is already outstanding). Each slot that qualifies and is not already waiting is appended to an ordered ready queue. When the queue holds at least one slot and no request is in flight, the oldest entry is granted. The block then computes that slot's fetch virtual address and byte length and presents a valid/ready request to the translation port.

The fetch address is the slot's base plus its program counter, advanced past the instructions already buffered. Each buffered entry is 4 bytes and each 8-byte instruction adds 4 more. The length runs to the end of the current cache line, so a request never crosses a line. A granted slot stays marked as fetch-pending until the fetch return path pulses `fetch_done` for it. A request the port does not take is held unchanged until it is accepted.

The control is a two-state machine. `ST_IDLE` holds no request. Its GRANT transition, taken when the ready queue is non-empty, pops the head slot, latches the address and length, and moves to `ST_HOLD`. `ST_HOLD` drives `req_valid` and makes no new grant. Its ACCEPT transition, taken when `req_ready` is high, returns to `ST_IDLE`.

Top module: `wave_fetch_arbiter`

## Requirements
- R1: A slot is eligible only when `slot_running` is 1, `slot_ib_count` is at most IB_LIMIT (default 4), `slot_branch` is 0 and its `slot_pending` bit is 0. A count of 5, a set branch flag or a clear running flag keeps the slot from ever being requested.
- R2: An eligible slot that is not already queued enters the ready queue once. It is not queued again until it has been granted, so a slot that stays eligible yields exactly one request per grant.
- R3: `req_valid` stays 0 while the ready queue is empty and no request is held.
- R4: A grant sets the chosen slot's `slot_pending` bit, which is visible by the time `req_valid` rises. The bit clears in the cycle after `fetch_done` is high with `fetch_done_slot` equal to that slot. While the bit is set, the slot is not requested again.
- R5: The ready queue is served oldest first. Slots that become eligible in the same cycle enter the queue in ascending slot index order.
- R6: `req_addr` equals `slot_base + slot_pc + 4*slot_ib_count + 4*slot_ib_wide` of the granted slot, modulo 2^ADDR_W. `slot_ib_wide` is the number of buffered 8-byte instructions.
- R7: `req_len` equals LINE_BYTES minus (`req_addr` mod LINE_BYTES) when the address is not line-aligned, and LINE_BYTES when it is aligned.
- R8: While `req_valid` is 1 and `req_ready` is 0, the request is held: in the next cycle `req_valid` is still 1 and `req_slot`, `req_addr` and `req_len` are unchanged.
- R9: At most one request is outstanding. In the cycle after a request is accepted, `req_valid` is 0.
- R10: After reset, `req_valid` is 0 and every `slot_pending` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_running | input | NUM_SLOTS | Slot is running |
| slot_branch | input | NUM_SLOTS | Slot's buffer holds a branch |
| slot_ib_count | input | NUM_SLOTS x IBC_W | Instructions held in each slot's buffer |
| slot_ib_wide | input | NUM_SLOTS x IBC_W | How many of those are 8-byte instructions |
| slot_base | input | NUM_SLOTS x ADDR_W | Slot base address |
| slot_pc | input | NUM_SLOTS x ADDR_W | Slot program counter (byte offset) |
| fetch_done | input | 1 | Fetch return for `fetch_done_slot` completed |
| fetch_done_slot | input | SLOT_W | Slot whose fetch completed |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Translation port accepts the request |
| req_slot | output | SLOT_W | Slot of the request |
| req_addr | output | ADDR_W | Fetch virtual address |
| req_len | output | LEN_W | Fetch length in bytes |
| slot_pending | output | NUM_SLOTS | Fetch-pending bit per slot |

## Verification
On every cycle the assertions check the following: a stalled request is held stable, a bubble follows each acceptance, the granted slot is marked pending, a request never crosses a line, and nothing is requested from an empty queue. Other behaviours depend on history across many cycles, and only the bench scenarios can show them. These are queue order across time and within one cycle, the exact address arithmetic, the eligibility boundary at four buffered entries, and re-issue after `fetch_done` for a slot that stays eligible. The scoreboard predicts each request from the slot inputs and compares slot, address and length at the moment of acceptance, both under a steady port and under an irregular stall pattern.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/fa_ready_queue.sv
// Ordered queue of slot indices; each slot is present at most once.
module fa_ready_queue #(
    parameter int DEPTH  = 8,
    parameter int SLOT_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  push_vec,
    input  logic              pop,
    output logic [SLOT_W-1:0] head_slot,
    output logic [CNT_W-1:0]  count,
    output logic              nonempty
);
    logic [SLOT_W-1:0] slots_q [DEPTH];
    logic [SLOT_W-1:0] slots_d [DEPTH];
    logic [CNT_W-1:0]  count_q, count_d;
    int unsigned       fill;

    always_comb begin
        slots_d = slots_q;
        fill    = 32'(count_q);
        if (pop && fill != 0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                slots_d[i] = slots_q[i + 1];
            end
            fill = fill - 1;
        end
        // lower slot index enters first when several arrive together
        for (int i = 0; i < DEPTH; i++) begin
            if (push_vec[i] && fill < DEPTH) begin
                slots_d[fill[SLOT_W-1:0]] = SLOT_W'(i);
                fill = fill + 1;
            end
        end
        count_d = CNT_W'(fill);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            count_q <= count_d;
            slots_q <= slots_d;
        end
    end

    assign head_slot = slots_q[0];
    assign count     = count_q;
    assign nonempty  = (count_q != '0);
endmodule

// File: rtl/fa_addr_calc.sv
// Fetch address past buffered instructions, length clipped at line end.
module fa_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int IBC_W      = 4,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pc,
    input  logic [IBC_W-1:0]  ib_count,
    input  logic [IBC_W-1:0]  ib_wide,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  len
);
    logic [ADDR_W-1:0] skip_bytes;
    logic [OFF_W-1:0]  line_off;

    assign skip_bytes = (ADDR_W'(ib_count) + ADDR_W'(ib_wide)) << 2;
    assign addr       = base + pc + skip_bytes;
    assign line_off   = addr[OFF_W-1:0];
    assign len        = (line_off == '0) ? LEN_W'(LINE_BYTES)
                                         : LEN_W'(LINE_BYTES) - LEN_W'(line_off);
endmodule

// File: rtl/wave_fetch_arbiter.sv
module wave_fetch_arbiter
    import fa_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int IBC_W      = 4,
    parameter int IB_LIMIT   = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SLOTS-1:0]                slot_running,
    input  logic [NUM_SLOTS-1:0]                slot_branch,
    input  logic [NUM_SLOTS-1:0][IBC_W-1:0]     slot_ib_count,
    input  logic [NUM_SLOTS-1:0][IBC_W-1:0]     slot_ib_wide,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_base,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]    slot_pc,
    input  logic                                fetch_done,
    input  logic [SLOT_W-1:0]                   fetch_done_slot,
    output logic                                req_valid,
    input  logic                                req_ready,
    output logic [SLOT_W-1:0]                   req_slot,
    output logic [ADDR_W-1:0]                   req_addr,
    output logic [LEN_W-1:0]                    req_len,
    output logic [NUM_SLOTS-1:0]                slot_pending
);
    localparam int QCNT_W = $clog2(NUM_SLOTS + 1);

    fetch_state_e          state_q, state_d;
    logic [NUM_SLOTS-1:0]  queued_q, pending_q, eligible, push_vec;
    logic [SLOT_W-1:0]     head_slot;
    logic [QCNT_W-1:0]     q_count;
    logic                  q_nonempty;
    logic                  grant;
    logic [ADDR_W-1:0]     calc_addr;
    logic [LEN_W-1:0]      calc_len;
    logic [SLOT_W-1:0]     slot_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [LEN_W-1:0]      len_q;

    // per-slot eligibility and flag state
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign eligible[g] = slot_running[g]
                           && (slot_ib_count[g] <= IBC_W'(IB_LIMIT))
                           && !slot_branch[g]
                           && !pending_q[g];
        assign push_vec[g] = eligible[g] && !queued_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                queued_q[g]  <= 1'b0;
                pending_q[g] <= 1'b0;
            end else begin
                if (push_vec[g])
                    queued_q[g] <= 1'b1;
                else if (grant && head_slot == SLOT_W'(g))
                    queued_q[g] <= 1'b0;

                if (grant && head_slot == SLOT_W'(g))
                    pending_q[g] <= 1'b1;
                else if (fetch_done && fetch_done_slot == SLOT_W'(g))
                    pending_q[g] <= 1'b0;
            end
        end
    end

    fa_ready_queue #(
        .DEPTH (NUM_SLOTS)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_vec  (push_vec),
        .pop       (grant),
        .head_slot (head_slot),
        .count     (q_count),
        .nonempty  (q_nonempty)
    );

    fa_addr_calc #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES),
        .IBC_W      (IBC_W)
    ) u_addr (
        .base     (slot_base[head_slot]),
        .pc       (slot_pc[head_slot]),
        .ib_count (slot_ib_count[head_slot]),
        .ib_wide  (slot_ib_wide[head_slot]),
        .addr     (calc_addr),
        .len      (calc_len)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (q_nonempty) state_d = ST_HOLD;   // GRANT
            ST_HOLD: if (req_ready)  state_d = ST_IDLE;   // ACCEPT
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        grant     = 1'b0;
        req_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: grant     = q_nonempty;
            ST_HOLD: req_valid = 1'b1;
            default: ;
        endcase
    end

    // request register, loaded on grant, held through stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            addr_q <= '0;
            len_q  <= '0;
        end else if (grant) begin
            slot_q <= head_slot;
            addr_q <= calc_addr;
            len_q  <= calc_len;
        end
    end

    assign req_slot     = slot_q;
    assign req_addr     = addr_q;
    assign req_len      = len_q;
    assign slot_pending = pending_q;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int NUM_SLOTS  = 8,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int SLOT_W     = $clog2(NUM_SLOTS),
    parameter int LEN_W      = $clog2(LINE_BYTES) + 1,
    parameter int QCNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [SLOT_W-1:0]    req_slot,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [LEN_W-1:0]     req_len,
    input logic [NUM_SLOTS-1:0] slot_pending,
    input logic [QCNT_W-1:0]    q_count
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_slot)
                                       && $stable(req_addr) && $stable(req_len)));

    // R9
    accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R4
    pending_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> slot_pending[req_slot]);

    // R7
    line_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0
                       && (LEN_W + 1)'(req_addr[OFF_W-1:0]) + (LEN_W + 1)'(req_len)
                          == (LEN_W + 1)'(LINE_BYTES)));

    // R3
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0 && !req_valid) |=> !req_valid);

    // R2
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCNT_W'(NUM_SLOTS));
endmodule

bind wave_fetch_arbiter fa_checker #(
    .NUM_SLOTS  (NUM_SLOTS),
    .LINE_BYTES (LINE_BYTES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_slot     (req_slot),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .slot_pending (slot_pending),
    .q_count      (q_count)
);

// File: tb/wave_fetch_arbiter_tb.sv
`timescale 1ns/100ps
module wave_fetch_arbiter_tb;
    localparam int N  = 8;
    localparam int LB = 64;
    localparam int AW = 32;
    localparam int IW = 4;
    localparam int SW = 3;
    localparam int LW = 7;

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]          running = '0, branch = '0;
    logic [N-1:0][IW-1:0]  ibc = '0, ibw = '0;
    logic [N-1:0][AW-1:0]  base = '0, pc = '0;
    logic                  done = 1'b0;
    logic [SW-1:0]         done_slot = '0;
    logic                  req_valid, req_ready;
    logic [SW-1:0]         req_slot;
    logic [AW-1:0]         req_addr;
    logic [LW-1:0]         req_len;
    logic [N-1:0]          pending;

    int checks = 0, errors = 0, n_accept = 0;
    exp_t sb[$];
    bit stall_en = 0, ready_force = 1;
    logic [3:0] pat = 4'd0;

    always #2.5 clk = ~clk;

    wave_fetch_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .slot_running(running), .slot_branch(branch),
        .slot_ib_count(ibc), .slot_ib_wide(ibw),
        .slot_base(base), .slot_pc(pc),
        .fetch_done(done), .fetch_done_slot(done_slot),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_slot(req_slot), .req_addr(req_addr), .req_len(req_len),
        .slot_pending(pending)
    );

    // port ready: set just after each rising edge
    always @(posedge clk) begin
        #1;
        pat = pat + 4'd3;
        req_ready = stall_en ? (pat[2] & pat[0]) : ready_force;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic set_slot(input int s, input bit run, input bit br, input int cnt,
                            input int wide, input logic [AW-1:0] b, input logic [AW-1:0] p);
        running[s] = run; branch[s] = br;
        ibc[s] = IW'(cnt); ibw[s] = IW'(wide);
        base[s] = b; pc[s] = p;
    endtask

    // driver side of the scoreboard: predicted request for a slot
    task automatic expect_req(input int s);
        exp_t e;
        logic [AW-1:0] a;
        a = base[s] + pc[s] + AW'(4 * (int'(ibc[s]) + int'(ibw[s])));
        e.slot = SW'(s);
        e.addr = a;
        e.len  = LW'(LB - int'(a % LB));
        sb.push_back(e);
    endtask

    task automatic complete(input int s);
        done = 1'b1; done_slot = SW'(s);
        step();
        done = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((sb.size() != 0 || req_valid) && t < 2000) begin
            step();
            t++;
        end
        check(sb.size() == 0, req, sb.size(), 0);
    endtask

    // monitor: compare at acceptance, check hold and gap
    logic          p_val = 0, p_rdy = 0;
    logic [SW-1:0] p_slot;
    logic [AW-1:0] p_addr;
    logic [LW-1:0] p_len;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_val && p_rdy)
                check(!req_valid, "R9 bubble after accept", req_valid, 0);
            if (p_val && !p_rdy)
                check(req_valid && req_slot == p_slot && req_addr == p_addr && req_len == p_len,
                      "R8 held request", req_addr, p_addr);
            if (req_valid && req_ready) begin
                n_accept++;
                if (sb.size() == 0) begin
                    check(0, "R3 unexpected request", req_slot, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(req_slot == e.slot, "R5 slot order", req_slot, e.slot);
                    check(req_addr == e.addr, "R6 address", req_addr, e.addr);
                    check(req_len == e.len, "R7 length", req_len, e.len);
                end
            end
            p_val = req_valid; p_rdy = req_ready;
            p_slot = req_slot; p_addr = req_addr; p_len = req_len;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base_cnt;
        step(3);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check(!req_valid, "R10 valid after reset", req_valid, 0);
        check(pending == '0, "R10 pending after reset", pending, 0);

        // R1/R3: ineligible slots never requested
        set_slot(0, 1, 0, 5, 0, 32'h1000_0000, 32'h0);
        set_slot(1, 1, 1, 1, 0, 32'h1000_0000, 32'h0);
        set_slot(2, 0, 0, 0, 0, 32'h1000_0000, 32'h0);
        base_cnt = n_accept;
        step(30);
        check(n_accept == base_cnt && !req_valid, "R1 R3 no request when ineligible",
              n_accept - base_cnt, 0);
        running = '0; branch = '0; ibc = '0;

        // R6/R7 misaligned, R4 pending, R2 single entry
        set_slot(3, 1, 0, 2, 1, 32'h1000_0000, 32'h0000_0100);
        expect_req(3);
        step();
        drain("R6 single slot drain");
        check(pending[3] == 1'b1, "R4 pending set", pending[3], 1);
        base_cnt = n_accept;
        step(20);
        check(n_accept == base_cnt, "R2 R4 no repeat while pending", n_accept - base_cnt, 0);
        expect_req(3);
        complete(3);
        drain("R4 reissue after done");
        running[3] = 1'b0;
        complete(3);
        step();
        check(pending[3] == 1'b0, "R4 pending cleared", pending[3], 0);

        // R1 boundary: count 4 eligible; aligned R7 case
        set_slot(6, 1, 0, 4, 4, 32'h3000_0000, 32'h0000_003C);
        set_slot(0, 1, 0, 0, 0, 32'h2000_0000, 32'h0000_0040);
        set_slot(4, 1, 0, 3, 0, 32'h0FFF_FFC0, 32'h0000_0030);
        set_slot(1, 1, 0, 1, 1, 32'h4000_0000, 32'h0000_0038);
        // same-cycle arrivals, R5 ascending order, with stalls (R8)
        stall_en = 1;
        expect_req(0); expect_req(1); expect_req(4); expect_req(6);
        step();
        drain("R5 same-cycle order");
        running = '0;
        for (int s = 0; s < N; s++) if (pending[s]) complete(s);
        step();
        check(pending == '0, "R4 all cleared", pending, 0);
        stall_en = 0;

        // R5 oldest first across cycles, with port blocked
        ready_force = 0;
        set_slot(5, 1, 0, 0, 0, 32'h5000_0000, 32'h0000_0004);
        expect_req(5);
        step(4);
        check(req_valid && req_slot == 3'd5, "R8 held while blocked", req_slot, 5);
        set_slot(7, 1, 0, 1, 0, 32'h5000_1000, 32'h0);
        expect_req(7); step();
        set_slot(2, 1, 0, 2, 2, 32'h5000_2000, 32'h0000_0020);
        expect_req(2); step();
        set_slot(0, 1, 0, 3, 1, 32'h5000_3000, 32'h0000_0030);
        expect_req(0); step();
        step(3);
        ready_force = 1;
        drain("R5 time order drain");
        running = '0;
        for (int s = 0; s < N; s++) if (pending[s]) complete(s);
        step(5);
        check(!req_valid && sb.size() == 0, "R3 idle at end", req_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule